// File: doc/BRIEF.md
# Directory Line Controller with Transparent Reads and Future-Sharer Tracking

This block is the directory logic for one cache line in an invalidate-based, fully mapped coherence scheme shared by `N_NODES` nodes. For the line it keeps a state (idle, shared or exclusive), the owning node, a bit vector of sharers and a bit vector of future sharers. Requests arrive one at a time over a ready/valid handshake. Each request carries a node number, a kind (read, transparent read, read-exclusive/upgrade, eviction) and a stream tag. The tag says whether the request comes from a main stream or from a run-ahead helper stream. Data is abstracted away: a reply carries only its kind, the destination node and a self-invalidation flag.

A helper stream that runs ahead of its main stream uses the transparent read to learn the line's future use. It does not take ownership away from the writer. If the line is exclusive to another node, the transparent read gets a possibly stale reply and never joins the sharers. The controller records the requester as a future sharer and sends the writer a hint to give the line up once its stores finish. Future sharers stay recorded until eviction or a main-stream request from that node. While they stay recorded, an exclusive reply to any later writer carries a self-invalidation flag. A helper issues transparent reads only when it is at least one session ahead of its main stream, or when it is inside a critical section. Otherwise it issues ordinary reads. That choice is made by the requester and reaches this block only through the request kind.

All directory fields change on the clock edge that accepts a request. Every reply, invalidation, forward and hint is a one-cycle registered pulse.

Top module: `dir_tload_ctrl`

## Requirements
- R1: After reset the line is idle (state code 0), owner 0, sharer and future vectors zero, `req_ready_o` high, and no pulse output is active.
- R2: A transparent read (kind 1) to a line exclusive (state 2) to another node gives a transparent reply (type 1) to the requester. Owner, state and sharer vector are unchanged and no forward is issued.
- R3: In the case of R2, a hint pulse is also sent to the current owner, and the requester's future-sharer bit is set.
- R4: A read (kind 0), or a transparent read, to an idle or shared line (state 0/1) makes the line shared and adds the requester to the sharers. It gives a normal reply (type 0). A transparent read also sets the requester's future bit. A read or transparent read by the current exclusive owner only gives a normal reply.
- R5: A read-exclusive (kind 2) makes the requester the exclusive owner and sole sharer. Every other former sharer, including a former owner, is named once in a one-cycle invalidation mask. The exclusive reply (type 2) follows one cycle after the acceptance if the mask is empty. Otherwise it follows one cycle after the last matching acknowledgement.
- R6: The self-invalidation flag of an exclusive reply is set exactly when the future-sharer vector is nonzero at the time of the reply.
- R7: A future-sharer bit is cleared when its node evicts the line (either stream) or sends any other request with the main-stream tag. A helper request other than an eviction never clears it.
- R8: Every output pulse appears in the cycle after the edge that caused it. `req_ready_o` is low from an accepted request that needs acknowledgements or a writeback until that event is taken. Acknowledgements that arrive while nothing is pending are ignored.
- R9: A read (kind 0) to a line exclusive to another node sends a forward to the owner. The line becomes shared with owner and requester as sharers, and a normal reply goes to the requester in the cycle after the writeback pulse.
- R10: An eviction (kind 3) removes the node from the sharers. The line becomes idle once no sharer remains, which includes the owner evicting an exclusive line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_type_i | input | 2 | 0 read, 1 transparent read, 2 read-exclusive/upgrade, 3 eviction |
| req_node_i | input | NODE_W | Requesting node |
| req_helper_i | input | 1 | 1 = helper stream, 0 = main stream |
| ack_valid_i | input | 1 | One invalidation acknowledgement |
| wb_valid_i | input | 1 | Owner writeback after a forward |
| rsp_valid_o | output | 1 | Reply pulse |
| rsp_type_o | output | 2 | 0 normal, 1 transparent, 2 exclusive |
| rsp_node_o | output | NODE_W | Reply destination |
| rsp_si_o | output | 1 | Self-invalidation flag on an exclusive reply |
| inv_valid_o | output | 1 | Invalidation pulse |
| inv_mask_o | output | N_NODES | Nodes to invalidate |
| fwd_valid_o | output | 1 | Forward-to-owner pulse |
| fwd_node_o | output | NODE_W | Owner receiving the forward |
| hint_valid_o | output | 1 | Self-invalidation hint pulse |
| hint_node_o | output | NODE_W | Owner receiving the hint |
| line_state_o | output | 2 | 0 idle, 1 shared, 2 exclusive |
| owner_o | output | NODE_W | Exclusive owner |
| sharers_o | output | N_NODES | Sharer vector |
| future_o | output | N_NODES | Future-sharer vector |

## Verification
The assertions check properties that hold between outputs in the same cycle. A transparent reply always comes with the line still exclusive, a hint, and a future bit for the requester. An invalidation never names the new owner. Every exclusive reply's flag matches the future vector. Forwards leave exactly two sharers, and the handshake is low whenever invalidations or forwards are outstanding.

Some behaviour spans several requests, and only the bench's reference model, compared every cycle, can show it. This covers future bits surviving helper traffic but not main-stream or eviction traffic, stalled requests completing in order after acknowledgements or writebacks, stray acknowledgements being ignored, and the line returning to idle.

// File: rtl/dir_tload_pkg.sv
package dir_tload_pkg;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_TRD = 2'd1, REQ_RDX = 2'd2, REQ_EVICT = 2'd3} req_e;
  typedef enum logic [1:0] {RSP_DATA = 2'd0, RSP_TDATA = 2'd1, RSP_EXCL = 2'd2} rsp_e;
  typedef enum logic [1:0] {LN_IDLE = 2'd0, LN_SHARED = 2'd1, LN_EXCL = 2'd2} line_e;
  typedef enum logic [1:0] {WT_NONE = 2'd0, WT_ACK = 2'd1, WT_WB = 2'd2} wait_e;
endpackage

// File: rtl/dir_line_next.sv
module dir_line_next
  import dir_tload_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int NODE_W  = 2
) (
  input  line_e              st_i,
  input  logic [NODE_W-1:0]  own_i,
  input  logic [N_NODES-1:0] shr_i,
  input  logic [N_NODES-1:0] fut_i,
  input  req_e               kind_i,
  input  logic [NODE_W-1:0]  node_i,
  input  logic               helper_i,
  output line_e              st_o,
  output logic [NODE_W-1:0]  own_o,
  output logic [N_NODES-1:0] shr_o,
  output logic [N_NODES-1:0] fut_o,
  output logic               rsp_en_o,
  output rsp_e               rsp_type_o,
  output logic               hint_en_o,
  output logic               fwd_en_o,
  output logic [N_NODES-1:0] inv_mask_o
);
  logic [N_NODES-1:0] bit_v, fut_base, shr_left;
  logic               excl_other;

  always_comb begin
    bit_v         = '0;
    bit_v[node_i] = 1'b1;
    fut_base      = helper_i ? fut_i : (fut_i & ~bit_v);
    excl_other    = (st_i == LN_EXCL) && (own_i != node_i);
    shr_left      = shr_i & ~bit_v;
    st_o          = st_i;
    own_o         = own_i;
    shr_o         = shr_i;
    fut_o         = fut_base;
    rsp_en_o      = 1'b0;
    rsp_type_o    = RSP_DATA;
    hint_en_o     = 1'b0;
    fwd_en_o      = 1'b0;
    inv_mask_o    = '0;
    unique case (kind_i)
      REQ_RD, REQ_TRD: begin
        if (excl_other) begin
          if (kind_i == REQ_TRD) begin
            // stale data to helper, writer keeps ownership
            rsp_en_o   = 1'b1;
            rsp_type_o = RSP_TDATA;
            hint_en_o  = 1'b1;
            fut_o      = fut_base | bit_v;
          end else begin
            fwd_en_o = 1'b1;
            st_o     = LN_SHARED;
            shr_o    = shr_i | bit_v;
          end
        end else if (st_i == LN_EXCL) begin
          rsp_en_o = 1'b1;
        end else begin
          st_o     = LN_SHARED;
          shr_o    = shr_i | bit_v;
          rsp_en_o = 1'b1;
          if (kind_i == REQ_TRD) fut_o = fut_base | bit_v;
        end
      end
      REQ_RDX: begin
        inv_mask_o = shr_left;
        st_o       = LN_EXCL;
        own_o      = node_i;
        shr_o      = bit_v;
        rsp_type_o = RSP_EXCL;
        rsp_en_o   = (shr_left == '0);
      end
      REQ_EVICT: begin
        fut_o = fut_i & ~bit_v;
        shr_o = shr_left;
        if (shr_left == '0) st_o = LN_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/dir_ack_counter.sv
module dir_ack_counter #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = dec_i && (cnt_q == W'(1));
endmodule

// File: rtl/dir_tload_ctrl.sv
module dir_tload_ctrl
  import dir_tload_pkg::*;
#(
  parameter int N_NODES = 4,
  localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_type_i,
  input  logic [NODE_W-1:0]  req_node_i,
  input  logic               req_helper_i,
  input  logic               ack_valid_i,
  input  logic               wb_valid_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_type_o,
  output logic [NODE_W-1:0]  rsp_node_o,
  output logic               rsp_si_o,
  output logic               inv_valid_o,
  output logic [N_NODES-1:0] inv_mask_o,
  output logic               fwd_valid_o,
  output logic [NODE_W-1:0]  fwd_node_o,
  output logic               hint_valid_o,
  output logic [NODE_W-1:0]  hint_node_o,
  output logic [1:0]         line_state_o,
  output logic [NODE_W-1:0]  owner_o,
  output logic [N_NODES-1:0] sharers_o,
  output logic [N_NODES-1:0] future_o
);
  localparam int CNT_W = $clog2(N_NODES + 1);

  line_e              st_q, n_st;
  wait_e              wait_q;
  logic [NODE_W-1:0]  own_q, n_own, rq_q;
  logic [N_NODES-1:0] shr_q, fut_q, n_shr, n_fut, n_inv;
  logic               n_rsp, n_hint, n_fwd, accept, ack_last;
  rsp_e               n_rtype;

  assign req_ready_o = (wait_q == WT_NONE);
  assign accept      = req_valid_i && req_ready_o;

  dir_line_next #(.N_NODES(N_NODES), .NODE_W(NODE_W)) u_next (
    .st_i       (st_q),
    .own_i      (own_q),
    .shr_i      (shr_q),
    .fut_i      (fut_q),
    .kind_i     (req_e'(req_type_i)),
    .node_i     (req_node_i),
    .helper_i   (req_helper_i),
    .st_o       (n_st),
    .own_o      (n_own),
    .shr_o      (n_shr),
    .fut_o      (n_fut),
    .rsp_en_o   (n_rsp),
    .rsp_type_o (n_rtype),
    .hint_en_o  (n_hint),
    .fwd_en_o   (n_fwd),
    .inv_mask_o (n_inv)
  );

  dir_ack_counter #(.W(CNT_W)) u_acks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && (n_inv != '0)),
    .load_val_i (CNT_W'($countones(n_inv))),
    .dec_i      ((wait_q == WT_ACK) && ack_valid_i),
    .last_o     (ack_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= LN_IDLE;
      own_q        <= '0;
      shr_q        <= '0;
      fut_q        <= '0;
      wait_q       <= WT_NONE;
      rq_q         <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_type_o   <= 2'd0;
      rsp_node_o   <= '0;
      rsp_si_o     <= 1'b0;
      inv_valid_o  <= 1'b0;
      inv_mask_o   <= '0;
      fwd_valid_o  <= 1'b0;
      fwd_node_o   <= '0;
      hint_valid_o <= 1'b0;
      hint_node_o  <= '0;
    end else begin
      rsp_valid_o  <= 1'b0;
      rsp_si_o     <= 1'b0;
      inv_valid_o  <= 1'b0;
      inv_mask_o   <= '0;
      fwd_valid_o  <= 1'b0;
      hint_valid_o <= 1'b0;
      if (accept) begin
        st_q         <= n_st;
        own_q        <= n_own;
        shr_q        <= n_shr;
        fut_q        <= n_fut;
        rq_q         <= req_node_i;
        rsp_valid_o  <= n_rsp;
        rsp_type_o   <= n_rtype;
        rsp_node_o   <= req_node_i;
        rsp_si_o     <= n_rsp && (n_rtype == RSP_EXCL) && (n_fut != '0);
        hint_valid_o <= n_hint;
        hint_node_o  <= own_q;
        fwd_valid_o  <= n_fwd;
        fwd_node_o   <= own_q;
        inv_valid_o  <= (n_inv != '0);
        inv_mask_o   <= n_inv;
        wait_q       <= n_fwd ? WT_WB : ((n_inv != '0) ? WT_ACK : WT_NONE);
      end else if (wait_q == WT_ACK && ack_last) begin
        rsp_valid_o <= 1'b1;
        rsp_type_o  <= RSP_EXCL;
        rsp_node_o  <= rq_q;
        rsp_si_o    <= (fut_q != '0);
        wait_q      <= WT_NONE;
      end else if (wait_q == WT_WB && wb_valid_i) begin
        rsp_valid_o <= 1'b1;
        rsp_type_o  <= RSP_DATA;
        rsp_node_o  <= rq_q;
        wait_q      <= WT_NONE;
      end
    end
  end

  assign line_state_o = st_q;
  assign owner_o      = own_q;
  assign sharers_o    = shr_q;
  assign future_o     = fut_q;
endmodule

// File: rtl/dir_tload_ctrl_chk.sv
module dir_tload_ctrl_chk
  import dir_tload_pkg::*;
#(
  parameter int N_NODES = 4,
  localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic [1:0]         rsp_type_o,
  input logic [NODE_W-1:0]  rsp_node_o,
  input logic               rsp_si_o,
  input logic               inv_valid_o,
  input logic [N_NODES-1:0] inv_mask_o,
  input logic               fwd_valid_o,
  input logic               hint_valid_o,
  input logic [1:0]         line_state_o,
  input logic [N_NODES-1:0] sharers_o,
  input logic [N_NODES-1:0] future_o
);
  p_tdata_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == RSP_TDATA) |->
      (line_state_o == LN_EXCL && !fwd_valid_o && !sharers_o[rsp_node_o]));

  p_tdata_hint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == RSP_TDATA) |-> (hint_valid_o && future_o[rsp_node_o]));

  p_read_share_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == RSP_DATA) |-> sharers_o[rsp_node_o]);

  p_inv_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> (line_state_o == LN_EXCL && (inv_mask_o & sharers_o) == '0));

  p_si_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == RSP_EXCL) |-> (rsp_si_o == (future_o != '0)));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_o || fwd_valid_o) |-> !req_ready_o);

  p_fwd_share_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (line_state_o == LN_SHARED && $countones(sharers_o) == 2));

  p_idle_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_state_o == LN_IDLE) |-> (sharers_o == '0));
endmodule

bind dir_tload_ctrl dir_tload_ctrl_chk #(.N_NODES(N_NODES)) u_chk (.*);

// File: tb/dir_tload_ctrl_tb.sv
`timescale 1ns/1ps
module dir_tload_ctrl_tb;
  localparam int N  = 4;
  localparam int NW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_type_i = 2'd0;
  logic [NW-1:0] req_node_i = '0;
  logic          req_helper_i = 1'b0;
  logic          ack_valid_i = 1'b0;
  logic          wb_valid_i = 1'b0;
  logic          rsp_valid_o, rsp_si_o, inv_valid_o, fwd_valid_o, hint_valid_o;
  logic [1:0]    rsp_type_o, line_state_o;
  logic [NW-1:0] rsp_node_o, fwd_node_o, hint_node_o, owner_o;
  logic [N-1:0]  inv_mask_o, sharers_o, future_o;

  always #2 clk_i = ~clk_i;

  dir_tload_ctrl #(.N_NODES(N)) u_dut (.*);

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;

  task automatic chk(string t, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", t, what, act, exp);
    end
  endtask

  // reference model: state 0 idle / 1 shared / 2 exclusive, wait 0 none / 1 acks / 2 writeback
  int         m_st, m_own, m_wait, m_cnt, m_rq;
  bit [N-1:0] m_shr, m_fut, e_im;
  bit         e_rv, e_si, e_hv, e_fv, e_iv;
  int         e_rt, e_rn, e_hn, e_fn;
  string      tag = "R1";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_own = 0; m_wait = 0; m_cnt = 0; m_rq = 0;
      m_shr = '0; m_fut = '0; e_im = '0;
      e_rv = 0; e_si = 0; e_hv = 0; e_fv = 0; e_iv = 0;
      e_rt = 0; e_rn = 0; e_hn = 0; e_fn = 0;
      tag = "R1";
    end else begin
      e_rv = 0; e_si = 0; e_hv = 0; e_fv = 0; e_iv = 0; e_im = '0;
      if (m_wait == 0 && req_valid_i) begin
        int n, k, c;
        n = int'(req_node_i); k = int'(req_type_i);
        if (!req_helper_i && k != 3) m_fut[n] = 1'b0;
        if (k == 3) begin
          m_fut[n] = 1'b0; m_shr[n] = 1'b0;
          if (m_shr == '0) m_st = 0;
          tag = "R10";
        end else if (k == 2) begin
          c = 0;
          for (int i = 0; i < N; i++)
            if (m_shr[i] && i != n) begin e_im[i] = 1'b1; c++; end
          m_st = 2; m_own = n; m_shr = '0; m_shr[n] = 1'b1; tag = "R5";
          if (c == 0) begin e_rv = 1; e_rt = 2; e_rn = n; e_si = (m_fut != '0); end
          else begin e_iv = 1; m_wait = 1; m_cnt = c; m_rq = n; end
        end else if (m_st == 2 && m_own != n) begin
          if (k == 1) begin
            e_rv = 1; e_rt = 1; e_rn = n; e_hv = 1; e_hn = m_own; m_fut[n] = 1'b1; tag = "R2";
          end else begin
            e_fv = 1; e_fn = m_own; m_st = 1; m_shr[n] = 1'b1; m_wait = 2; m_rq = n; tag = "R9";
          end
        end else begin
          if (m_st != 2) begin
            m_st = 1; m_shr[n] = 1'b1;
            if (k == 1) m_fut[n] = 1'b1;
          end
          e_rv = 1; e_rt = 0; e_rn = n; tag = "R4";
        end
      end else if (m_wait == 1 && ack_valid_i) begin
        m_cnt--;
        if (m_cnt == 0) begin
          e_rv = 1; e_rt = 2; e_rn = m_rq; e_si = (m_fut != '0); m_wait = 0;
        end
      end else if (m_wait == 2 && wb_valid_i) begin
        e_rv = 1; e_rt = 0; e_rn = m_rq; m_wait = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R8", "ready", req_ready_o, m_wait == 0);
      chk(tag, "rsp_valid", rsp_valid_o, e_rv);
      if (e_rv) begin
        chk(tag, "rsp_type", rsp_type_o, e_rt);
        chk(tag, "rsp_node", rsp_node_o, e_rn);
      end
      chk("R6", "rsp_si", rsp_si_o, e_si);
      chk("R3", "hint_valid", hint_valid_o, e_hv);
      if (e_hv) chk("R3", "hint_node", hint_node_o, e_hn);
      chk("R9", "fwd_valid", fwd_valid_o, e_fv);
      if (e_fv) chk("R9", "fwd_node", fwd_node_o, e_fn);
      chk("R5", "inv_valid", inv_valid_o, e_iv);
      chk("R5", "inv_mask", inv_mask_o, e_im);
      chk(tag, "line_state", line_state_o, m_st);
      chk(tag, "sharers", sharers_o, m_shr);
      if (m_st == 2) chk("R5", "owner", owner_o, m_own);
      chk("R7", "future", future_o, m_fut);
    end
  end

  // responder: acknowledgements with gaps, writeback after a delay, optional stray acks
  int pend = 0, wbd = 0;
  bit tog = 1'b0, stray_en = 1'b0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pend = 0; wbd = 0; ack_valid_i = 1'b0; wb_valid_i = 1'b0;
    end else begin
      if (inv_valid_o) pend += $countones(inv_mask_o);
      if (fwd_valid_o) wbd = 3;
      tog = ~tog;
      ack_valid_i = tog && (pend > 0 || stray_en);
      if (ack_valid_i && pend > 0) pend--;
      if (wbd > 0) begin wbd--; wb_valid_i = (wbd == 0); end
      else wb_valid_i = 1'b0;
    end
  end

  task automatic send(int k, int n, bit h);
    @(negedge clk_i);
    req_type_i = 2'(k); req_node_i = NW'(n); req_helper_i = h; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    chk("R1", "ready in reset", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "state", line_state_o, 0);
    chk("R1", "sharers", sharers_o, 0);
    chk("R1", "future", future_o, 0);
    chk("R1", "rsp_valid", rsp_valid_o, 0);

    send(0, 0, 0);        // R4 read on idle
    send(1, 1, 1);        // R4 transparent on shared sets future
    send(2, 2, 0);        // R5 invalidate 0,1; R6 flag set
    send(0, 3, 0);        // R8 stalled, then R9 forward
    send(2, 0, 0);        // R5 invalidate 2,3
    send(1, 3, 1);        // R2/R3 transparent on exclusive
    send(1, 1, 1);        // R2 with future already set
    send(0, 1, 1);        // R9 helper read keeps future bit, R7
    send(0, 1, 0);        // R7 main request clears future
    send(3, 3, 1);        // R7 eviction clears future
    send(2, 2, 0);        // R6 flag clear
    send(0, 2, 0);        // R4 owner self-read
    send(2, 2, 0);        // R5 upgrade with no other sharer
    stray_en = 1'b1;      // R8 stray acks ignored
    send(3, 2, 0);        // R10 owner evicts -> idle
    send(3, 1, 0);        // R10 evict of non-sharer
    send(2, 1, 0);        // R5 idle write, immediate reply
    stray_en = 1'b0;

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stray_en = lfsr[9];
      send(int'(lfsr[1:0]), int'(lfsr[3:2]), lfsr[4]);
    end
    repeat (20) @(negedge clk_i);
    finish_run();
  end
endmodule